// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block turns one 16-byte data descriptor into an ordered stream of (address, length) segments for a DMA engine. A descriptor whose entry count is zero is direct: it names one data buffer and its length, so the walker emits that single segment. A descriptor whose count is non-zero is indirect: its address points to a packed list of that many direct descriptors, and its byte count is the total length of all their buffers. Only one level of indirection is allowed.

For an indirect descriptor, the walker reads the list one entry at a time over a request/response memory port that returns 128-bit words. It emits each entry as a segment on a valid/ready output and keeps a running sum of the entry lengths to compare with the declared total. The walk ends with a one-cycle `done` pulse that carries a completion code. Code 0 means success. Code 1 reports a misaligned list base, 14 an excessive count, 30 a nested indirect entry, and 33 a length mismatch.

The controller is a five-state machine:
- `S_IDLE` accepts `start`. It moves to `S_EMIT` for a direct descriptor, to `S_DONE` when the count or the base alignment is rejected, and to `S_FETCH` otherwise.
- `S_FETCH` holds a read request. It moves to `S_WAIT` on `mem_req_ready`.
- `S_WAIT` waits for the response. It moves to `S_DONE` on a nested entry or an overflow, and to `S_EMIT` otherwise.
- `S_EMIT` presents a segment. When the segment is accepted, it moves to `S_FETCH` for the next entry, or to `S_DONE` after the last entry or after a direct segment.
- `S_DONE` pulses `done` and always returns to `S_IDLE`.

Top module: `sg_list_walker`

## Requirements
- R1: A descriptor is 128 bits with byte 0 in bits [127:120]. The entry count is bits [111:104], the total byte count is bits [95:64], and the address is bits [63:0]. The walker reads memory responses in the same layout.
- R2: A descriptor with count 0 produces exactly one segment, carrying its own address and byte count, and then `done` with code 0. No memory read is issued.
- R3: A descriptor with count N in 1..MAX_ENTRIES and a 16-byte-aligned address reads entry i at address base+16*i, in ascending order. The walker emits the segments in list order, and `done` carries code 0 when the lengths sum exactly to the total.
- R4: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` stay unchanged in the next cycle.
- R5: A count greater than MAX_ENTRIES (default 256) ends the walk with code 14. No memory read is issued and no segment is emitted.
- R6: An indirect descriptor whose address has a non-zero value in bits [3:0] ends the walk with code 1. No read is issued and no segment is emitted.
- R7: A list entry with a non-zero count ends the walk with code 30. Neither that entry nor any later entry is emitted.
- R8: If adding an entry's length makes the running sum exceed the declared total, the walk ends with code 33 and that entry is not emitted.
- R9: If the sum of all entry lengths is below the declared total, every segment is still emitted, and the walk then ends with code 33.
- R10: Each walk produces exactly one `done` pulse, one cycle long. A `start` received while a walk is in progress is ignored.
- R11: A memory request holds its address while `mem_req_ready` is low. At most one read is outstanding, and a new request waits for the previous response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with `desc_in` (taken only when idle) |
| desc_in | input | 128 | Descriptor in memory byte order |
| mem_req_valid | output | 1 | List entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | List entry returned by memory |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment length in bytes |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_code | output | 8 | Completion code, valid with `done` |

## Verification
The assertions check the following on every cycle:
- a held segment and a held request stay stable under backpressure;
- request addresses are aligned;
- only one read is outstanding at a time;
- `done` lasts a single cycle and carries only a legal code;
- no read follows an excessive count.

Only the bench's scenarios can show which code each malformed list produces and that the right segments appear in the right order. The bench sweeps every list length up to the maximum and beyond it, and places a nested or overflowing entry at every position. It also covers short totals, misaligned bases and a `start` during a walk, all under pseudo-random backpressure on both ports.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int DESC_W = 128;
    localparam int ADDR_W = 64;
    localparam int LEN_W  = 32;
    localparam int CNT_W  = 8;
    localparam int ENTRY_BYTES_LOG2 = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_EMIT,
        S_DONE
    } sgw_state_e;

    localparam logic [7:0] CODE_OK       = 8'd0;
    localparam logic [7:0] CODE_ALIGN    = 8'd1;
    localparam logic [7:0] CODE_EXCESS   = 8'd14;
    localparam logic [7:0] CODE_BAD_DESC = 8'd30;
    localparam logic [7:0] CODE_OVERFLOW = 8'd33;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } sgw_desc_t;

endpackage

// File: rtl/sgw_desc_unpack.sv
module sgw_desc_unpack
    import sgw_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output sgw_desc_t         fields
);
    // Count byte sits at big-endian bits 16..23 of the first word.
    localparam int CNT_LSB = DESC_W - 1 - 23;
    localparam int LEN_LSB = ADDR_W;

    logic unused_rsvd;
    assign unused_rsvd = ^{raw[DESC_W-1:CNT_LSB+CNT_W], raw[LEN_LSB+LEN_W+7:LEN_LSB+LEN_W]};

    assign fields.cnt  = raw[CNT_LSB +: CNT_W];
    assign fields.len  = raw[LEN_LSB +: LEN_W];
    assign fields.addr = raw[0 +: ADDR_W];
endmodule

// File: rtl/sgw_len_tracker.sv
module sgw_len_tracker #(
    parameter int LEN_W = 32,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [LEN_W-1:0] total_in,
    input  logic             add,
    input  logic [LEN_W-1:0] add_len,
    output logic             would_exceed,
    output logic             falls_short
);
    localparam int SUM_W = LEN_W + IDX_W;

    logic [SUM_W-1:0] sum_q;
    logic [LEN_W-1:0] total_q;
    logic [SUM_W-1:0] sum_next;

    assign sum_next     = sum_q + SUM_W'(add_len);
    assign would_exceed = sum_next > SUM_W'(total_q);
    assign falls_short  = sum_q < SUM_W'(total_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            total_q <= '0;
        end else if (clear) begin
            sum_q   <= '0;
            total_q <= total_in;
        end else if (add) begin
            sum_q   <= sum_next;
        end
    end
endmodule

// File: rtl/sg_list_walker.sv
module sg_list_walker
    import sgw_pkg::*;
#(
    parameter int MAX_ENTRIES = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [127:0]       desc_in,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [63:0]        mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [127:0]       mem_rsp_data,
    output logic               seg_valid,
    input  logic               seg_ready,
    output logic [63:0]        seg_addr,
    output logic [31:0]        seg_len,
    output logic               done,
    output logic [7:0]         done_code
);
    localparam int IDX_W = $clog2(MAX_ENTRIES + 1);

    sgw_state_e        state_q, state_d;
    sgw_desc_t         start_f, rsp_f;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  cnt_q, idx_q;
    logic              direct_q;
    logic [ADDR_W-1:0] seg_addr_q;
    logic [LEN_W-1:0]  seg_len_q;
    logic [7:0]        code_q, code_d;
    logic              would_exceed, falls_short;
    logic              take_start, take_entry, last_entry;

    sgw_desc_unpack u_unpack_start (.raw(desc_in),      .fields(start_f));
    sgw_desc_unpack u_unpack_rsp   (.raw(mem_rsp_data), .fields(rsp_f));

    assign take_start = (state_q == S_IDLE) && start;
    assign take_entry = (state_q == S_WAIT) && mem_rsp_valid
                        && (rsp_f.cnt == '0) && !would_exceed;
    assign last_entry = IDX_W'(idx_q + 1'b1) == cnt_q;

    sgw_len_tracker #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (take_start),
        .total_in     (start_f.len),
        .add          (take_entry),
        .add_len      (rsp_f.len),
        .would_exceed (would_exceed),
        .falls_short  (falls_short)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and completion code
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (start_f.cnt == '0) begin
                        state_d = S_EMIT;
                        code_d  = CODE_OK;
                    end else if (int'(start_f.cnt) > MAX_ENTRIES) begin
                        state_d = S_DONE;
                        code_d  = CODE_EXCESS;
                    end else if (start_f.addr[ENTRY_BYTES_LOG2-1:0] != '0) begin
                        state_d = S_DONE;
                        code_d  = CODE_ALIGN;
                    end else begin
                        state_d = S_FETCH;
                        code_d  = CODE_OK;
                    end
                end
            end
            S_FETCH: begin
                if (mem_req_ready) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    if (rsp_f.cnt != '0) begin
                        state_d = S_DONE;
                        code_d  = CODE_BAD_DESC;
                    end else if (would_exceed) begin
                        state_d = S_DONE;
                        code_d  = CODE_OVERFLOW;
                    end else begin
                        state_d = S_EMIT;
                    end
                end
            end
            S_EMIT: begin
                if (seg_ready) begin
                    if (direct_q) begin
                        state_d = S_DONE;
                        code_d  = CODE_OK;
                    end else if (last_entry) begin
                        state_d = S_DONE;
                        code_d  = falls_short ? CODE_OVERFLOW : CODE_OK;
                    end else begin
                        state_d = S_FETCH;
                    end
                end
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            cnt_q      <= '0;
            idx_q      <= '0;
            direct_q   <= 1'b0;
            seg_addr_q <= '0;
            seg_len_q  <= '0;
            code_q     <= CODE_OK;
        end else begin
            code_q <= code_d;
            if (take_start) begin
                base_q     <= start_f.addr;
                cnt_q      <= IDX_W'(start_f.cnt);
                idx_q      <= '0;
                direct_q   <= (start_f.cnt == '0);
                seg_addr_q <= start_f.addr;
                seg_len_q  <= start_f.len;
            end
            if (take_entry) begin
                seg_addr_q <= rsp_f.addr;
                seg_len_q  <= rsp_f.len;
            end
            if ((state_q == S_EMIT) && seg_ready && !direct_q) begin
                idx_q <= IDX_W'(idx_q + 1'b1);
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req_valid = 1'b0;
        seg_valid     = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_FETCH: mem_req_valid = 1'b1;
            S_WAIT:  ;
            S_EMIT:  seg_valid = 1'b1;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign mem_req_addr = base_q + (ADDR_W'(idx_q) << ENTRY_BYTES_LOG2);
    assign seg_addr     = seg_addr_q;
    assign seg_len      = seg_len_q;
    assign done_code    = code_q;

endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int MAX_ENTRIES = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_idle,
    input logic        start,
    input logic [7:0]  start_cnt,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic        rsp_valid,
    input logic        seg_valid,
    input logic        seg_ready,
    input logic [63:0] seg_addr,
    input logic [31:0] seg_len,
    input logic        done,
    input logic [7:0]  done_code
);
    logic excess_walk_q;
    logic outstanding_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            excess_walk_q <= 1'b0;
            outstanding_q <= 1'b0;
        end else begin
            if (in_idle && start && (int'(start_cnt) > MAX_ENTRIES)) excess_walk_q <= 1'b1;
            else if (done)                                           excess_walk_q <= 1'b0;
            if (req_valid && req_ready) outstanding_q <= 1'b1;
            else if (rsp_valid)         outstanding_q <= 1'b0;
        end
    end

    a_r4_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding_q |-> !req_valid);

    a_r3_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[3:0] == 4'h0);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_code == 8'd0 || done_code == 8'd1 || done_code == 8'd14
                  || done_code == 8'd30 || done_code == 8'd33));

    a_r5_no_read_on_excess: assert property (@(posedge clk) disable iff (!rst_n)
        excess_walk_q |-> !req_valid && !seg_valid);

    a_r5_excess_code: assert property (@(posedge clk) disable iff (!rst_n)
        excess_walk_q && done |-> done_code == 8'd14);

    a_r2_one_port_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_valid && req_valid));

endmodule

bind sg_list_walker sgw_checker #(.MAX_ENTRIES(MAX_ENTRIES)) u_sgw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_idle   (state_q == sgw_pkg::S_IDLE),
    .start     (start),
    .start_cnt (desc_in[111:104]),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_addr  (mem_req_addr),
    .rsp_valid (mem_rsp_valid),
    .seg_valid (seg_valid),
    .seg_ready (seg_ready),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .done      (done),
    .done_code (done_code)
);

// File: tb/tb_sg_list_walker.sv
module tb_sg_list_walker;
    localparam int MAXE = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] desc_in = '0;
    logic         mem_req_valid, mem_req_ready;
    logic [63:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_data = '0;
    logic         seg_valid, seg_ready;
    logic [63:0]  seg_addr;
    logic [31:0]  seg_len;
    logic         done;
    logic [7:0]   done_code;

    always #4 clk = ~clk;

    sg_list_walker #(.MAX_ENTRIES(MAXE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_in(desc_in),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .done(done), .done_code(done_code)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [127:0] mem_img [0:7];
    logic [63:0]  cur_base = '0;
    int           n_reads = 0, n_segs = 0, n_done = 0;
    logic [7:0]   last_code = '0;
    logic [63:0]  got_addr [0:7];
    logic [31:0]  got_len  [0:7];
    logic [15:0]  lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [7:0] c, input logic [31:0] l, input logic [63:0] a);
        return {16'h0, c, 8'h0, l, a};
    endfunction

    // Memory model, segment sink and done monitor, all on the falling edge
    initial begin
        bit          pend = 0;
        int          pidx = 0;
        bit          hold = 0;
        logic [63:0] h_addr = '0;
        logic [31:0] h_len = '0;
        mem_req_ready = 1'b0;
        seg_ready = 1'b0;
        forever begin
            @(negedge clk);
            cycles++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_img[pidx];
                pend = 0;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            mem_req_ready = lfsr[0] | lfsr[3];
            if (mem_req_valid && mem_req_ready && rst_n) begin
                chk(mem_req_addr == cur_base + 64'(n_reads * 16), "R3 read order",
                    longint'(mem_req_addr), longint'(cur_base + 64'(n_reads * 16)));
                pidx = int'((mem_req_addr - cur_base) >> 4) & 7;
                pend = 1;
                n_reads++;
            end
            if (hold) begin
                chk(seg_valid && seg_addr == h_addr && seg_len == h_len, "R4 hold",
                    longint'(seg_len), longint'(h_len));
            end
            seg_ready = lfsr[5] | lfsr[9];
            hold = seg_valid && !seg_ready;
            h_addr = seg_addr;
            h_len = seg_len;
            if (seg_valid && seg_ready && rst_n) begin
                if (n_segs < 8) begin
                    got_addr[n_segs] = seg_addr;
                    got_len[n_segs]  = seg_len;
                end
                n_segs++;
            end
            if (done && rst_n) begin
                n_done++;
                last_code = done_code;
            end
        end
    end

    // kind: 0 exact, 1 nested entry at pos, 2 overflow at pos, 3 short total
    task automatic run_case(input int count, input bit misalign, input int kind,
                            input int pos, input bit extra_start);
        logic [63:0] ea [0:7];
        logic [31:0] el [0:7];
        longint      sum_all = 0, total = 0, run = 0;
        int          exp_segs, exp_reads;
        logic [7:0]  exp_code;
        string       tag;
        int          waited;
        logic [63:0] base;
        base = misalign ? 64'h8008 : 64'h8000;
        for (int i = 0; i < 8; i++) begin
            ea[i] = 64'h0000_0040_0000_0000 + 64'(i * 'h1000) + 64'(count);
            el[i] = 32'(8 * (i + 1) + count * 3);
            mem_img[i] = mk((kind == 1 && i == pos) ? 8'd1 : 8'd0, el[i], ea[i]);
            if (i < count) sum_all += el[i];
        end
        total = sum_all;
        if (kind == 2) begin
            total = 0;
            for (int i = 0; i <= pos; i++) total += el[i];
            total = total - 1;
        end
        if (kind == 3) total = sum_all + 7;
        if (count == 0) begin
            ea[0] = 64'hDEAD_0000_0000_0003 + 64'(kind);
            el[0] = 32'(100 + kind);
            total = el[0];
            base  = ea[0];
        end
        // Expected outcome
        exp_segs = 0; exp_reads = 0; exp_code = 8'd0; tag = "R3";
        if (count == 0) begin
            exp_segs = 1; tag = "R2";
        end else if (count > MAXE) begin
            exp_code = 8'd14; tag = "R5";
        end else if (misalign) begin
            exp_code = 8'd1; tag = "R6";
        end else begin
            exp_segs = count; exp_reads = count;
            for (int i = 0; i < count; i++) begin
                if (kind == 1 && i == pos) begin
                    exp_code = 8'd30; exp_segs = i; exp_reads = i + 1; tag = "R7";
                    break;
                end
                run += el[i];
                if (run > total) begin
                    exp_code = 8'd33; exp_segs = i; exp_reads = i + 1; tag = "R8";
                    break;
                end
            end
            if (tag == "R3" && run < total) begin
                exp_code = 8'd33; tag = "R9";
            end
        end
        // Drive the walk
        @(negedge clk);
        cur_base = base;
        n_reads = 0; n_segs = 0; n_done = 0;
        start = 1'b1;
        desc_in = mk(8'(count), 32'(total), base);
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (n_done == 0 && waited < 600) begin
            @(negedge clk);
            waited++;
            if (extra_start && waited == 3) begin
                start = 1'b1;
                desc_in = mk(8'd0, 32'd5, 64'h1234);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(n_done == 1, "R10 one done", n_done, 1);
        chk(last_code == exp_code, tag, last_code, exp_code);
        chk(n_segs == exp_segs, {tag, " segments"}, n_segs, exp_segs);
        chk(n_reads == exp_reads, {tag, " reads"}, n_reads, exp_reads);
        for (int i = 0; i < exp_segs && i < 8; i++) begin
            chk(got_addr[i] == ea[i], {tag, " R1 addr"}, longint'(got_addr[i]), longint'(ea[i]));
            chk(got_len[i] == el[i], {tag, " R1 len"}, longint'(got_len[i]), longint'(el[i]));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!seg_valid && !mem_req_valid && !done, "R10 reset idle", seg_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int c = 0; c <= MAXE + 2; c++) begin
            run_case(c, 0, 0, 0, 0);
            if (c >= 1 && c <= MAXE) begin
                run_case(c, 0, 3, 0, 0);
                run_case(c, 1, 0, 0, 0);
                for (int p = 0; p < c; p++) begin
                    run_case(c, 0, 1, p, 0);
                    run_case(c, 0, 2, p, 0);
                end
            end
        end
        run_case(8'd200, 0, 0, 0, 0);
        run_case(3, 0, 0, 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule